// File: doc/BRIEF.md
# Boot Strap Configuration Latch

This block captures a handful of strap pins while the system is held in reset and keeps them as the boot configuration once reset is released. From the straps it produces the external bus-type field (data width and address mode), the write-strobe configuration, a byte-high-enable disable flag and a chip-select enable mask. The mask is expanded from a 2-bit count code, and its complement marks the pins that are left free for general-purpose I/O.

A two-state sequencer controls the latch. It is in `ST_SAMPLE` while reset is high, and every clock edge in that state reloads the registers from the pins. The first clock edge with reset low is the `release` transition: that edge makes one last capture and moves the sequencer to `ST_HOLD`. In `ST_HOLD` the captured strap values are frozen. Software may then rewrite the bus-type field and the write-configuration bit through a one-cycle write strobe. Asserting reset from any state is the `reset` transition, which returns the sequencer asynchronously to `ST_SAMPLE`. `ST_HOLD` has one transition, `stay`, back to itself.

Top module: `boot_strap_latch`

## Requirements
- R1: While reset is high, each clock edge reloads every output from the current pins. With all pins high and the internal-start strap low, the outputs after reset are bus type 2'b11, write config 0, byte-high disable 0 and chip-select mask 5'b11111.
- R2: The bus-type field is {bus_pins_i[1], bus_pins_i[0]}. Bit 1 gives the data width (1 = 16-bit, 0 = 8-bit) and bit 0 gives the address mode (1 = multiplexed, 0 = demultiplexed). This gives 00 = 8-bit demux, 01 = 8-bit mux, 10 = 16-bit demux and 11 = 16-bit mux.
- R3: When int_start_i is high at a capture edge, the bus pins are ignored and the bus-type field becomes 2'b00.
- R4: rp_wrc_o holds the write-config pin exactly as captured. wr_cfg_o holds the inverse of that pin (0 = common write with byte-high strobe, 1 = separate high and low write strobes).
- R5: The chip-select code maps to an enable mask in which lower bits are set first: 2'b11 gives 5'b11111, 2'b10 gives 5'b00000, 2'b01 gives 5'b00011 and 2'b00 gives 5'b00111. cssel_o returns the captured code.
- R6: gpio_free_o is the bitwise complement of cs_en_o.
- R7: bhe_dis_o is 1 exactly when bus-type bit 1 is 0. It follows software writes to that bit from the cycle after the write.
- R8: In ST_HOLD, changes on the strap pins or on int_start_i have no effect on any output.
- R9: In ST_HOLD, a cycle with sw_we_i high loads sw_bus_type_i and sw_wr_cfg_i, and the new values appear after that edge. rp_wrc_o, cssel_o and the chip-select mask are not writable.
- R10: A software write on the release edge is ignored, and the strap capture takes effect instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | System reset, active high, asynchronous to the sequencer |
| bus_pins_i | input | 2 | Bus-type straps: [1] data width, [0] address mode |
| wrc_pin_i | input | 1 | Write-configuration strap |
| cssel_pins_i | input | 2 | Chip-select count strap code |
| int_start_i | input | 1 | Internal-start strap; forces the bus type to 00 |
| sw_we_i | input | 1 | Software write strobe |
| sw_bus_type_i | input | 2 | Bus-type value to write |
| sw_wr_cfg_i | input | 1 | Write-config value to write |
| bus_type_o | output | 2 | Current bus-type field |
| bhe_dis_o | output | 1 | Byte-high-enable disable |
| wr_cfg_o | output | 1 | Write-configuration control bit |
| rp_wrc_o | output | 1 | Raw captured write-config strap |
| cssel_o | output | 2 | Captured chip-select code |
| cs_en_o | output | 5 | Per-pin chip-select enable |
| gpio_free_o | output | 5 | Pins released for general-purpose I/O |

## Verification
On the release edge, the final strap capture and a software write can land in the same cycle. The bench provokes this by raising the write strobe in the same half-cycle in which reset falls, with write values that differ from the straps. It then checks that the outputs after that edge show the strap values. Because the strobe is held high for one more cycle, the bench also sees the write take effect one edge later, which shows that only the release edge suppressed it.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;

    typedef enum logic [0:0] {
        ST_SAMPLE = 1'b0,
        ST_HOLD   = 1'b1
    } strap_state_e;

    // Number of active chip selects for each strap code
    function automatic int unsigned cs_count(input logic [1:0] code);
        int unsigned n;
        unique case (code)
            2'b11:   n = 5;
            2'b10:   n = 0;
            2'b01:   n = 2;
            default: n = 3;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/boot_strap_fsm.sv
module boot_strap_fsm
    import boot_strap_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output logic capture_o,
    output logic hold_o
);

    strap_state_e state_q;
    strap_state_e state_d;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= ST_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SAMPLE: state_d = ST_HOLD;   // release
            ST_HOLD:   state_d = ST_HOLD;   // stay
            default:   state_d = ST_SAMPLE;
        endcase
    end

    always_comb begin
        capture_o = 1'b0;
        hold_o    = 1'b0;
        unique case (state_q)
            ST_SAMPLE: capture_o = 1'b1;
            ST_HOLD:   hold_o    = 1'b1;
            default:   capture_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/boot_strap_csdec.sv
module boot_strap_csdec
    import boot_strap_pkg::*;
#(
    parameter int CS_NUM  = 5,
    parameter int CODE_W  = 2
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CS_NUM-1:0] mask_o
);

    int unsigned active_n;

    always_comb begin
        active_n = cs_count(code_i);
    end

    for (genvar i = 0; i < CS_NUM; i++) begin : g_lane
        assign mask_o[i] = (i < active_n);
    end

endmodule

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
    import boot_strap_pkg::*;
#(
    parameter int CS_NUM  = 5,
    parameter int BT_W    = 2,
    parameter int CSSEL_W = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [BT_W-1:0]    bus_pins_i,
    input  logic               wrc_pin_i,
    input  logic [CSSEL_W-1:0] cssel_pins_i,
    input  logic               int_start_i,
    input  logic               sw_we_i,
    input  logic [BT_W-1:0]    sw_bus_type_i,
    input  logic               sw_wr_cfg_i,
    output logic [BT_W-1:0]    bus_type_o,
    output logic               bhe_dis_o,
    output logic               wr_cfg_o,
    output logic               rp_wrc_o,
    output logic [CSSEL_W-1:0] cssel_o,
    output logic [CS_NUM-1:0]  cs_en_o,
    output logic [CS_NUM-1:0]  gpio_free_o
);

    localparam int WIDTH_BIT = BT_W - 1;

    logic               capture;
    logic               hold;
    logic [BT_W-1:0]    bt_q;
    logic               wrcfg_q;
    logic               rpwrc_q;
    logic [CSSEL_W-1:0] cssel_q;
    logic [BT_W-1:0]    bt_strap;

    boot_strap_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .capture_o (capture),
        .hold_o    (hold)
    );

    assign bt_strap = int_start_i ? '0 : bus_pins_i;

    // Strap capture takes priority over software writes
    always_ff @(posedge clk_i) begin
        if (capture) begin
            bt_q    <= bt_strap;
            wrcfg_q <= ~wrc_pin_i;
            rpwrc_q <= wrc_pin_i;
            cssel_q <= cssel_pins_i;
        end else if (hold && sw_we_i) begin
            bt_q    <= sw_bus_type_i;
            wrcfg_q <= sw_wr_cfg_i;
        end
    end

    boot_strap_csdec #(
        .CS_NUM (CS_NUM),
        .CODE_W (CSSEL_W)
    ) u_csdec (
        .code_i (cssel_q),
        .mask_o (cs_en_o)
    );

    assign bus_type_o  = bt_q;
    assign bhe_dis_o   = ~bt_q[WIDTH_BIT];
    assign wr_cfg_o    = wrcfg_q;
    assign rp_wrc_o    = rpwrc_q;
    assign cssel_o     = cssel_q;
    assign gpio_free_o = ~cs_en_o;

endmodule

// File: rtl/boot_strap_chk.sv
module boot_strap_chk #(
    parameter int CS_NUM = 5
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              capture,
    input logic              hold,
    input logic [1:0]        bus_pins_i,
    input logic              wrc_pin_i,
    input logic              int_start_i,
    input logic              sw_we_i,
    input logic [1:0]        sw_bus_type_i,
    input logic              sw_wr_cfg_i,
    input logic [1:0]        bus_type_o,
    input logic              bhe_dis_o,
    input logic              wr_cfg_o,
    input logic              rp_wrc_o,
    input logic [1:0]        cssel_o,
    input logic [CS_NUM-1:0] cs_en_o,
    input logic [CS_NUM-1:0] gpio_free_o
);

    a_r3_istart_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        capture && int_start_i |=> bus_type_o == 2'b00);

    a_r4_wrcfg_inverted: assert property (@(posedge clk_i) disable iff (rst_i)
        capture |=> (rp_wrc_o == $past(wrc_pin_i)) && (wr_cfg_o != rp_wrc_o));

    a_r5_none_code: assert property (@(posedge clk_i) disable iff (rst_i)
        hold && cssel_o == 2'b10 |-> cs_en_o == '0);

    a_r5_prefix_shape: assert property (@(posedge clk_i) disable iff (rst_i)
        hold |-> ((({1'b0, cs_en_o} + 1'b1) & {1'b0, cs_en_o}) == '0));

    a_r6_disjoint: assert property (@(posedge clk_i) disable iff (rst_i)
        hold |-> (cs_en_o & gpio_free_o) == '0);

    a_r7_bhe_after_write: assert property (@(posedge clk_i) disable iff (rst_i)
        hold && sw_we_i |=> bhe_dis_o == !$past(sw_bus_type_i[1]));

    a_r8_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        hold && !sw_we_i |=> $stable(bus_type_o) && $stable(wr_cfg_o)
                             && $stable(rp_wrc_o) && $stable(cssel_o));

    a_r9_sw_write: assert property (@(posedge clk_i) disable iff (rst_i)
        hold && sw_we_i |=> bus_type_o == $past(sw_bus_type_i)
                            && wr_cfg_o == $past(sw_wr_cfg_i));

    a_r10_capture_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        capture && !int_start_i |=> bus_type_o == $past(bus_pins_i));

endmodule

bind boot_strap_latch boot_strap_chk #(.CS_NUM(CS_NUM)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .capture       (capture),
    .hold          (hold),
    .bus_pins_i    (bus_pins_i),
    .wrc_pin_i     (wrc_pin_i),
    .int_start_i   (int_start_i),
    .sw_we_i       (sw_we_i),
    .sw_bus_type_i (sw_bus_type_i),
    .sw_wr_cfg_i   (sw_wr_cfg_i),
    .bus_type_o    (bus_type_o),
    .bhe_dis_o     (bhe_dis_o),
    .wr_cfg_o      (wr_cfg_o),
    .rp_wrc_o      (rp_wrc_o),
    .cssel_o       (cssel_o),
    .cs_en_o       (cs_en_o),
    .gpio_free_o   (gpio_free_o)
);

// File: tb/boot_strap_latch_test.sv
`timescale 1ns/1ps
module boot_strap_latch_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_pins = 2'b11;
    logic       wrc_pin = 1'b1;
    logic [1:0] cssel_pins = 2'b11;
    logic       int_start = 1'b0;
    logic       sw_we = 1'b0;
    logic [1:0] sw_bt = 2'b00;
    logic       sw_wrcfg = 1'b0;

    logic [1:0] bus_type;
    logic       bhe_dis;
    logic       wr_cfg;
    logic       rp_wrc;
    logic [1:0] cssel;
    logic [4:0] cs_en;
    logic [4:0] gpio_free;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    boot_strap_latch uut (
        .clk_i         (clk),
        .rst_i         (rst),
        .bus_pins_i    (bus_pins),
        .wrc_pin_i     (wrc_pin),
        .cssel_pins_i  (cssel_pins),
        .int_start_i   (int_start),
        .sw_we_i       (sw_we),
        .sw_bus_type_i (sw_bt),
        .sw_wr_cfg_i   (sw_wrcfg),
        .bus_type_o    (bus_type),
        .bhe_dis_o     (bhe_dis),
        .wr_cfg_o      (wr_cfg),
        .rp_wrc_o      (rp_wrc),
        .cssel_o       (cssel),
        .cs_en_o       (cs_en),
        .gpio_free_o   (gpio_free)
    );

    function automatic logic [4:0] exp_mask(input logic [1:0] code);
        case (code)
            2'b11:   return 5'b11111;
            2'b10:   return 5'b00000;
            2'b01:   return 5'b00011;
            default: return 5'b00111;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Hold reset for one edge with the given straps, then release; returns in hold state
    task automatic boot(input logic [1:0] bt, input logic istart,
                        input logic wrc, input logic [1:0] cs);
        @(negedge clk);
        rst = 1'b1; sw_we = 1'b0;
        bus_pins = bt; int_start = istart; wrc_pin = wrc; cssel_pins = cs;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_follow();
        @(negedge clk);
        rst = 1'b1; bus_pins = 2'b11; wrc_pin = 1'b1; cssel_pins = 2'b11; int_start = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 default bus type", {6'd0, bus_type}, 8'h03);
        check("R1 default wr cfg", {7'd0, wr_cfg}, 8'h00);
        check("R1 default bhe dis", {7'd0, bhe_dis}, 8'h00);
        check("R1 default cs mask", {3'd0, cs_en}, 8'h1f);
        bus_pins = 2'b01; cssel_pins = 2'b10; wrc_pin = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 follows bus pins in reset", {6'd0, bus_type}, 8'h01);
        check("R1 follows cs pins in reset", {3'd0, cs_en}, 8'h00);
        check("R1 follows wrc in reset", {7'd0, wr_cfg}, 8'h01);
    endtask

    task automatic t_bus_types();
        for (int i = 0; i < 4; i++) begin
            boot(i[1:0], 1'b0, 1'b1, 2'b11);
            check("R2 bus type code", {6'd0, bus_type}, i[7:0]);
            check("R7 bhe from width", {7'd0, bhe_dis}, {7'd0, ~i[1]});
        end
    endtask

    task automatic t_istart();
        boot(2'b11, 1'b1, 1'b1, 2'b11);
        check("R3 internal start clears bus type", {6'd0, bus_type}, 8'h00);
        check("R3 internal start bhe dis", {7'd0, bhe_dis}, 8'h01);
    endtask

    task automatic t_wrc();
        boot(2'b11, 1'b0, 1'b0, 2'b11);
        check("R4 raw wrc low", {7'd0, rp_wrc}, 8'h00);
        check("R4 inverted cfg", {7'd0, wr_cfg}, 8'h01);
        boot(2'b11, 1'b0, 1'b1, 2'b11);
        check("R4 raw wrc high", {7'd0, rp_wrc}, 8'h01);
        check("R4 inverted cfg std", {7'd0, wr_cfg}, 8'h00);
    endtask

    task automatic t_cs();
        for (int i = 0; i < 4; i++) begin
            boot(2'b11, 1'b0, 1'b1, i[1:0]);
            check("R5 cs mask", {3'd0, cs_en}, {3'd0, exp_mask(i[1:0])});
            check("R5 cssel readback", {6'd0, cssel}, i[7:0]);
            check("R6 gpio free", {3'd0, gpio_free}, {3'd0, ~exp_mask(i[1:0])});
        end
    endtask

    task automatic t_freeze();
        boot(2'b10, 1'b0, 1'b1, 2'b01);
        bus_pins = 2'b01; wrc_pin = 1'b0; cssel_pins = 2'b11; int_start = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R8 bus type frozen", {6'd0, bus_type}, 8'h02);
        check("R8 wrc frozen", {6'd0, rp_wrc, wr_cfg}, 8'h02);
        check("R8 cs frozen", {3'd0, cs_en}, 8'h03);
        int_start = 1'b0;
    endtask

    task automatic t_sw_write();
        boot(2'b11, 1'b0, 1'b1, 2'b00);
        sw_we = 1'b1; sw_bt = 2'b01; sw_wrcfg = 1'b1;
        @(posedge clk); @(negedge clk);
        sw_we = 1'b0;
        check("R9 sw bus type", {6'd0, bus_type}, 8'h01);
        check("R9 sw wr cfg", {7'd0, wr_cfg}, 8'h01);
        check("R9 raw wrc not writable", {7'd0, rp_wrc}, 8'h01);
        check("R9 cs not writable", {3'd0, cs_en}, 8'h07);
        check("R7 bhe after sw write", {7'd0, bhe_dis}, 8'h01);
        sw_we = 1'b1; sw_bt = 2'b10; sw_wrcfg = 1'b0;
        @(posedge clk); @(negedge clk);
        sw_we = 1'b0;
        check("R7 bhe after width set", {7'd0, bhe_dis}, 8'h00);
    endtask

    task automatic t_write_on_release();
        @(negedge clk);
        rst = 1'b1; sw_we = 1'b0;
        bus_pins = 2'b11; int_start = 1'b0; wrc_pin = 1'b1; cssel_pins = 2'b11;
        @(posedge clk); @(negedge clk);
        rst = 1'b0; sw_we = 1'b1; sw_bt = 2'b00; sw_wrcfg = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 capture wins bus type", {6'd0, bus_type}, 8'h03);
        check("R10 capture wins wr cfg", {7'd0, wr_cfg}, 8'h00);
        @(posedge clk); @(negedge clk);
        sw_we = 1'b0;
        check("R10 write lands next edge", {6'd0, bus_type}, 8'h00);
    endtask

    initial begin
        t_reset_follow();
        t_bus_types();
        t_istart();
        t_wrc();
        t_cs();
        t_freeze();
        t_sw_write();
        t_write_on_release();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule